// File: doc/BRIEF.md
# Destination Address Filter with Group Hash

This block sits at the front of a receive path and decides, from the 48-bit destination address of each incoming frame, whether the frame should be kept. Address bytes arrive one per cycle on a byte stream that carries a valid strobe and a start-of-frame flag. While the bytes are taken, the block stores them and folds each one into a reflected CRC-32. After the sixth byte it presents a one-cycle decision: accept or reject.

Individual (unicast) addresses must equal the programmed station address. Group addresses are looked up in a 64-entry bit table indexed by the top six bits of the CRC. The all-ones broadcast address always passes. A promiscuous control input forces acceptance. The station address and the two halves of the hash table are plain inputs, held by the register file of the surrounding receive path. The owner clears both table halves when it brings the path up.

The control state machine has three states. `ST_IDLE` waits for a start-of-frame byte. `ST_COLLECT` takes address bytes 1 to 5. `ST_DECIDE` presents the decision for one cycle. The transitions are:
- `ST_IDLE`→`ST_COLLECT` on a start byte.
- `ST_COLLECT`→`ST_COLLECT` on a new start byte, which restarts the frame.
- `ST_COLLECT`→`ST_DECIDE` when the sixth byte is taken.
- `ST_DECIDE`→`ST_COLLECT` on a start byte in the decision cycle.
- `ST_DECIDE`→`ST_IDLE` otherwise.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `accept` are both low.
- R2: A byte is taken as address byte 0 only when `in_valid` and `in_sof` are both high. While no frame is being collected, bytes with `in_valid` high and `in_sof` low are ignored.
- R3: `dec_valid` is high for exactly one cycle. That cycle is the one right after the sixth address byte is taken. Cycles with `in_valid` low between address bytes are gaps and take no byte.
- R4: A start byte that arrives before the sixth byte abandons the partial address, and a new address starts with that byte as byte 0.
- R5: An address is individual when bit 0 of byte 0 is 0. Such an address is accepted only if all six bytes equal the station address. Bytes 0 to 3 are `station_lo[8k+7:8k]`, byte 4 is `station_hi[7:0]` and byte 5 is `station_hi[15:8]`.
- R6: An address is a group address when bit 0 of byte 0 is 1. A group address is accepted when its table bit is set. The CRC is the reflected CRC-32 with polynomial 0xEDB88320. It is preset to all ones, takes each byte least significant bit first, and is not inverted at the end. The index is CRC bits 31:26. Index bit 5 selects `hash_hi` (1) or `hash_lo` (0), and index bits 4:0 select the bit within that half.
- R7: The address FF:FF:FF:FF:FF:FF is accepted whatever the table holds.
- R8: With `promisc_en` high in the decision cycle, the frame is accepted whatever the address, station and table.
- R9: After the sixth byte, further bytes without `in_sof` are ignored until the next start byte, and no second decision is produced.
- R10: A start byte in the decision cycle begins a new address. The decision for the previous address is still presented in that same cycle.
- R11: `accept` is never high while `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_sof | input | 1 | The present byte is the first byte of a frame |
| in_data | input | 8 | Destination address byte |
| promisc_en | input | 1 | Accept every frame |
| station_lo | input | 32 | Station address bytes 0 to 3, byte 0 lowest |
| station_hi | input | 16 | Station address bytes 4 and 5, byte 4 lowest |
| hash_lo | input | 32 | Group table entries 0 to 31 |
| hash_hi | input | 32 | Group table entries 32 to 63 |
| dec_valid | output | 1 | Decision is presented this cycle |
| accept | output | 1 | Frame is accepted (only meaningful with `dec_valid`) |

## Verification
Two functions can fall in the same cycle: presenting the decision for one address and taking byte 0 of the next. A directed case provokes this by driving the next start byte exactly in the decision cycle. In that cycle the bench checks the previous frame's verdict, and six bytes later it checks the new frame's verdict against its own address. A second overlap, a restart arriving mid-address, is judged by requiring that only the restarted address yields a decision.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2
    } filt_state_e;

    localparam int          CRC_WIDTH    = 32;
    localparam logic [31:0] CRC_POLY_REF = 32'hEDB8_8320;

endpackage

// File: rtl/addr_crc_unit.sv
// Byte-wide reflected CRC accumulator; exposes only the top index bits.
module addr_crc_unit #(
    parameter int                    CRC_W  = 32,
    parameter logic [CRC_W-1:0]      POLY   = 32'hEDB8_8320,
    parameter int                    IDX_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic             load,
    input  logic [7:0]       din,
    output logic [IDX_W-1:0] hash_idx
);

    logic [CRC_W-1:0]       crc_q;
    logic [8:0][CRC_W-1:0]  stage;

    assign stage[0] = (preset ? {CRC_W{1'b1}} : crc_q) ^ {{(CRC_W-8){1'b0}}, din};

    generate
        for (genvar b = 0; b < 8; b++) begin : g_bit
            assign stage[b+1] = (stage[b] >> 1) ^ (stage[b][0] ? POLY : {CRC_W{1'b0}});
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= {CRC_W{1'b1}};
        end else if (load) begin
            crc_q <= stage[8];
        end
    end

    assign hash_idx = crc_q[CRC_W-1 -: IDX_W];

endmodule

// File: rtl/addr_byte_capture.sv
// Stores the destination address byte lanes as they are taken.
module addr_byte_capture #(
    parameter int N_BYTES = 6,
    parameter int IDX_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [IDX_W-1:0]     idx,
    input  logic [7:0]           din,
    output logic [8*N_BYTES-1:0] addr_q
);

    generate
        for (genvar k = 0; k < N_BYTES; k++) begin : g_lane
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_q[8*k +: 8] <= 8'h00;
                end else if (load && (idx == IDX_W'(k))) begin
                    addr_q[8*k +: 8] <= din;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/addr_match.sv
// Combinational verdict from the captured address and the hash index.
module addr_match #(
    parameter int N_BYTES   = 6,
    parameter int HASH_BITS = 6,
    localparam int ADDR_W   = 8 * N_BYTES,
    localparam int HALF_W   = (1 << HASH_BITS) / 2
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          station_lo,
    input  logic [ADDR_W-33:0]   station_hi,
    input  logic [HALF_W-1:0]    hash_lo,
    input  logic [HALF_W-1:0]    hash_hi,
    input  logic [HASH_BITS-1:0] hash_idx,
    output logic                 hit
);

    logic [2*HALF_W-1:0] table_bits;
    logic                is_group;
    logic                is_bcast;
    logic                uni_hit;
    logic                grp_hit;

    always_comb begin
        table_bits = {hash_hi, hash_lo};
        is_group   = addr[0];
        is_bcast   = &addr;
        uni_hit    = (addr == {station_hi, station_lo});
        grp_hit    = table_bits[hash_idx];
        hit        = is_bcast | (is_group ? grp_hit : uni_hit);
    end

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import addr_filter_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int ST_HI_W   = ADDR_W - 32,
    localparam int HALF_W    = (1 << HASH_BITS) / 2,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [7:0]         in_data,
    input  logic               promisc_en,
    input  logic [31:0]        station_lo,
    input  logic [ST_HI_W-1:0] station_hi,
    input  logic [HALF_W-1:0]  hash_lo,
    input  logic [HALF_W-1:0]  hash_hi,
    output logic               dec_valid,
    output logic               accept
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    filt_state_e          state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic                 first_byte;
    logic                 take_byte;
    logic [CNT_W-1:0]     lane_idx;
    logic [ADDR_W-1:0]    addr_q;
    logic [HASH_BITS-1:0] hash_idx;
    logic                 match_hit;

    assign first_byte = in_valid && in_sof;
    assign take_byte  = in_valid && (in_sof || (state_q == ST_COLLECT));
    assign lane_idx   = first_byte ? '0 : cnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (first_byte) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (first_byte) begin
                    state_d = ST_COLLECT;
                end else if (take_byte && (cnt_q == LAST_IDX)) begin
                    state_d = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                state_d = first_byte ? ST_COLLECT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and byte counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (first_byte) begin
                cnt_q <= CNT_W'(1);
            end else if (take_byte) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        dec_valid = 1'b0;
        accept    = 1'b0;
        unique case (state_q)
            ST_DECIDE: begin
                dec_valid = 1'b1;
                accept    = promisc_en | match_hit;
            end
            default: begin
                dec_valid = 1'b0;
                accept    = 1'b0;
            end
        endcase
    end

    addr_crc_unit #(
        .CRC_W (CRC_WIDTH),
        .POLY  (CRC_POLY_REF),
        .IDX_W (HASH_BITS)
    ) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset   (first_byte),
        .load     (take_byte),
        .din      (in_data),
        .hash_idx (hash_idx)
    );

    addr_byte_capture #(
        .N_BYTES (ADDR_BYTES),
        .IDX_W   (CNT_W)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take_byte),
        .idx    (lane_idx),
        .din    (in_data),
        .addr_q (addr_q)
    );

    addr_match #(
        .N_BYTES   (ADDR_BYTES),
        .HASH_BITS (HASH_BITS)
    ) u_match (
        .addr       (addr_q),
        .station_lo (station_lo),
        .station_hi (station_hi),
        .hash_lo    (hash_lo),
        .hash_hi    (hash_hi),
        .hash_idx   (hash_idx),
        .hit        (match_hit)
    );

endmodule

// File: rtl/dest_addr_filter_chk.sv
module dest_addr_filter_chk #(
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sof,
    input logic [7:0]        in_data,
    input logic              promisc_en,
    input logic [31:0]       station_lo,
    input logic [ADDR_W-33:0] station_hi,
    input logic              dec_valid,
    input logic              accept
);

    logic [CNT_W-1:0]  seen_cnt;
    logic              sixth_taken;
    logic [ADDR_W-1:0] addr_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_cnt    <= '0;
            sixth_taken <= 1'b0;
            addr_c      <= '0;
        end else if (in_valid && in_sof) begin
            seen_cnt        <= CNT_W'(1);
            sixth_taken     <= (ADDR_BYTES == 1);
            addr_c[7:0]     <= in_data;
        end else if (in_valid && (seen_cnt != '0) && (seen_cnt < CNT_W'(ADDR_BYTES))) begin
            seen_cnt                  <= seen_cnt + CNT_W'(1);
            sixth_taken               <= (seen_cnt + CNT_W'(1) == CNT_W'(ADDR_BYTES));
            addr_c[8*seen_cnt +: 8]   <= in_data;
        end else begin
            sixth_taken <= 1'b0;
        end
    end

    // R3
    decision_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid == sixth_taken);

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R11
    accept_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> dec_valid);

    // R8
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && promisc_en) |-> accept);

    // R7
    bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (&addr_c)) |-> accept);

    // R5
    unicast_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !promisc_en && !addr_c[0] && (addr_c != {station_hi, station_lo})) |-> !accept);

endmodule

bind dest_addr_filter dest_addr_filter_chk #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_data    (in_data),
    .promisc_en (promisc_en),
    .station_lo (station_lo),
    .station_hi (station_hi),
    .dec_valid  (dec_valid),
    .accept     (accept)
);

// File: tb/dest_addr_filter_tb.sv
module dest_addr_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        promisc_en = 1'b0;
    logic [31:0] station_lo = 32'h0;
    logic [15:0] station_hi = 16'h0;
    logic [31:0] hash_lo = 32'h0;
    logic [31:0] hash_hi = 32'h0;
    logic        dec_valid;
    logic        accept;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dest_addr_filter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_data    (in_data),
        .promisc_en (promisc_en),
        .station_lo (station_lo),
        .station_hi (station_hi),
        .hash_lo    (hash_lo),
        .hash_hi    (hash_hi),
        .dec_valid  (dec_valid),
        .accept     (accept)
    );

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[0] ^ a[i];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        return c;
    endfunction

    function automatic logic ref_accept(input logic [47:0] a, input logic pr,
                                        input logic [47:0] st, input logic [63:0] tbl);
        logic [31:0] c;
        if (pr) return 1'b1;
        if (&a) return 1'b1;
        if (a[0]) begin
            c = ref_crc(a);
            return tbl[c[31:26]];
        end
        return a == st;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic put(input logic [7:0] b, input bit s);
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = s;
        in_data  = b;
    endtask

    task automatic gap();
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_data  = 8'($urandom);
    endtask

    // bytes 1..5 of an address, optional random gaps
    task automatic send_tail(input logic [47:0] a, input int maxgap);
        for (int k = 1; k < 6; k++) begin
            if (maxgap > 0) repeat ($urandom_range(maxgap, 0)) gap();
            put(a[8*k +: 8], 1'b0);
            if (k == 5) chk(dec_valid == 1'b0, "R3 no early decision", 32'(dec_valid), 32'd0);
        end
    endtask

    task automatic send(input logic [47:0] a, input int maxgap);
        put(a[7:0], 1'b1);
        send_tail(a, maxgap);
    endtask

    task automatic decide(input logic expv, input string tag);
        gap();
        chk(dec_valid == 1'b1, "R3 decision cycle", 32'(dec_valid), 32'd1);
        chk(accept == expv, tag, 32'(accept), 32'(expv));
        gap();
        chk(dec_valid == 1'b0, "R3 single cycle", 32'(dec_valid), 32'd0);
        chk(accept == 1'b0, "R11 accept gated", 32'(accept), 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [47:0] st, a, b;
        logic [63:0] tbl;
        logic [31:0] c;
        void'($urandom(32'd1234));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dec_valid == 1'b0, "R1 reset dec_valid", 32'(dec_valid), 32'd0);
        chk(accept == 1'b0, "R1 reset accept", 32'(accept), 32'd0);

        st = 48'h5A4B_3C2D_1E02;
        {station_hi, station_lo} = st;
        tbl = 64'h0;
        {hash_hi, hash_lo} = tbl;

        // R2: stray bytes without a start flag are ignored
        for (int i = 0; i < 8; i++) begin
            put(8'($urandom), 1'b0);
            chk(dec_valid == 1'b0, "R2 stray bytes ignored", 32'(dec_valid), 32'd0);
        end
        gap();
        chk(dec_valid == 1'b0, "R2 stray bytes ignored", 32'(dec_valid), 32'd0);
        send(st, 0);
        decide(1'b1, "R5 station match");

        // R5: one-byte mismatch rejects
        send(st ^ 48'h0100_0000_0000, 2);
        decide(1'b0, "R5 station mismatch");

        // R4: restart mid-address
        put(8'h00, 1'b1); put(8'h11, 1'b0); put(8'h22, 1'b0);
        send(st, 1);
        decide(1'b1, "R4 restart takes new address");

        // R6: single table bit selected by index
        a = 48'h0100_5E00_0001 | 48'h1;
        c = ref_crc(a);
        tbl = 64'd1 << c[31:26];
        {hash_hi, hash_lo} = tbl;
        send(a, 0);
        decide(1'b1, "R6 selected bit set");
        {hash_hi, hash_lo} = ~tbl;
        send(a, 0);
        decide(1'b0, "R6 selected bit clear");
        {hash_hi, hash_lo} = 64'hFFFF_FFFF_FFFF_FFFF;
        send(a, 1);
        decide(1'b1, "R6 all ones table");
        {hash_hi, hash_lo} = 64'h0;
        send(a, 1);
        decide(1'b0, "R6 zero table");

        // R7: broadcast with empty table
        send(48'hFFFF_FFFF_FFFF, 0);
        decide(1'b1, "R7 broadcast accepted");

        // R8: promiscuous
        promisc_en = 1'b1;
        send(48'h1234_5678_9A00, 0);
        decide(1'b1, "R8 promiscuous");
        promisc_en = 1'b0;

        // R9: trailing bytes ignored, no second decision
        send(st, 0);
        decide(1'b1, "R9 frame before trailer");
        for (int i = 0; i < 10; i++) begin
            put(8'($urandom), 1'b0);
            chk(dec_valid == 1'b0, "R9 trailing bytes ignored", 32'(dec_valid), 32'd0);
        end
        gap();
        chk(dec_valid == 1'b0, "R9 trailing bytes ignored", 32'(dec_valid), 32'd0);

        // R10: next start byte in the decision cycle
        b = st ^ 48'h0000_0000_0100;
        send(st, 0);
        put(b[7:0], 1'b1);
        chk(dec_valid == 1'b1, "R10 decision alongside start", 32'(dec_valid), 32'd1);
        chk(accept == 1'b1, "R10 previous verdict", 32'(accept), 32'd1);
        send_tail(b, 0);
        decide(1'b0, "R10 new frame verdict");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int kind = $urandom_range(4, 0);
            st = {16'($urandom), 32'($urandom)} & ~48'h1;
            {station_hi, station_lo} = st;
            tbl = {32'($urandom), 32'($urandom)};
            {hash_hi, hash_lo} = tbl;
            promisc_en = ($urandom_range(7, 0) == 0);
            case (kind)
                0: a = st;
                1: a = {16'($urandom), 32'($urandom)} & ~48'h1;
                2, 3: a = {16'($urandom), 32'($urandom)} | 48'h1;
                default: a = 48'hFFFF_FFFF_FFFF;
            endcase
            send(a, 2);
            decide(ref_accept(a, promisc_en, st, tbl),
                   promisc_en ? "R8 random" : (kind == 4 ? "R7 random" :
                   (a[0] ? "R6 random" : "R5 random")));
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule